// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Controller

This block manages the directory entries of one memory module in a directory-based cache coherence system. Every memory block has an entry with a small, fixed set of hardware sharer pointers, one valid bit per pointer, and a state: uncached, shared, exclusive or overflow. A read request records the requesting node in a free pointer. A write request invalidates every other recorded node, one invalidation per cycle, and counts the returned acknowledgements before it grants exclusive ownership to the writer.

When a read would need more pointers than the entry has, the controller does not evict or broadcast. It raises a trap to the local processor, and software then tracks the sharer set in local memory. The block stays in the overflow state, so every later request to it also traps. The trap is held until the processor answers with a trap-done pulse. Meanwhile, requests to the trapped block, and any other request that would need a trap, are refused with a NACK. When the pointer count is set to zero, every request traps and coherence is handled entirely in software.

Requests use a single-cycle valid pulse. Only one invalidation run is in progress at a time, and every request that arrives during it is refused.

Top module: `limptr_dir`

## Requirements
- R1: After reset, no response, NACK, invalidation or trap output is active, and every block is uncached.
- R2: A read from a node not yet recorded, to an uncached or shared block with a free pointer, records the node in the lowest free pointer. The next cycle shows `rsp_valid` with `rsp_kind` = 0 (shared grant) and `rsp_node` = requester.
- R3: A read from a node already recorded for the block is granted shared and consumes no further pointer. Four distinct readers still fit after repeats.
- R4: A read from a new node to a shared block whose pointers are all in use raises a trap. The next cycle shows `rsp_kind` = 2 (trapped), and `trap_valid` carries the block, the node and `trap_write` = 0. The block enters the overflow state.
- R5: `trap_valid` and its fields stay unchanged until `trap_done` is sampled, and it is low in the following cycle. While it is high, a request to the trapped block gets `nak_valid` with `nak_node` one cycle later, and requests to other blocks are served normally.
- R6: Every later read or write to a block in overflow traps (`rsp_kind` = 2, `trap_write` giving the request type).
- R7: A write invalidates each recorded node other than the writer, one `inv_valid` pulse per cycle, in ascending pointer order, starting the cycle after the request. The exclusive grant (`rsp_kind` = 1) comes two cycles after the edge that samples the last `ack_valid`. The writer then becomes the sole owner.
- R8: A write to a block with no recorded node other than the writer is granted exclusive (`rsp_kind` = 1) the next cycle, with no invalidation.
- R9: A read from a node other than the owner of an exclusive block invalidates the owner, then grants shared, and leaves the reader as the only sharer. A read from the owner itself is granted shared with no invalidation.
- R10: Every request that arrives while an invalidation run is in progress gets `nak_valid` with its node the next cycle.
- R11: With zero hardware pointers, every read and every write traps (`rsp_kind` = 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_node | input | NODE_W | Requesting node |
| req_blk | input | BLK_W | Block index |
| ack_valid | input | 1 | One invalidation acknowledgement |
| trap_done | input | 1 | Software has finished the outstanding trap |
| rsp_valid | output | 1 | Response to the requester |
| rsp_kind | output | 2 | 0 shared grant, 1 exclusive grant, 2 trapped |
| rsp_node | output | NODE_W | Node the response goes to |
| nak_valid | output | 1 | Request refused |
| nak_node | output | NODE_W | Node that was refused |
| inv_valid | output | 1 | Invalidation to send this cycle |
| inv_node | output | NODE_W | Node to invalidate |
| trap_valid | output | 1 | Trap to the local processor outstanding |
| trap_blk | output | BLK_W | Block that trapped |
| trap_node | output | NODE_W | Node whose request trapped |
| trap_write | output | 1 | The trapping request was a write |

## Verification
Grants that need no invalidation, traps and NACKs are registered, so each appears in the cycle right after the edge that samples the request. Invalidations begin in that same cycle and follow one per cycle. An exclusive or recall grant appears two cycles after the edge that samples the last acknowledgement. The driver pushes each expected response, NACK and invalidation into a scoreboard queue, tagged with the bench cycle in which it is due. The monitor samples at falling edges, flags any output that arrives early, late, unexpected or with the wrong node or kind, and reports any expected item that never arrives.

// File: rtl/limptr_pkg.sv
// Shared types for the limited-pointer directory controller.
// Assumes: nothing beyond IEEE 1800-2017.
package limptr_pkg;

    typedef enum logic [1:0] {
        BLK_UNCACHED = 2'd0,
        BLK_SHARED   = 2'd1,
        BLK_EXCL     = 2'd2,
        BLK_OVERFLOW = 2'd3
    } blk_state_e;

    typedef enum logic [1:0] {
        RSP_SHARED  = 2'd0,
        RSP_EXCL    = 2'd1,
        RSP_TRAPPED = 2'd2
    } rsp_kind_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_BUSY = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/lpd_entry_store.sv
// Directory entry array: per block a state, pointer valid bits and pointers.
// Assumes: one write per cycle; the read is combinational on rd_blk.
module lpd_entry_store
    import limptr_pkg::*;
#(
    parameter int NODE_W = 6,
    parameter int SLOTS  = 4,
    parameter int BLK_W  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [BLK_W-1:0]               rd_blk,
    output blk_state_e                     rd_state,
    output logic [SLOTS-1:0]               rd_valid,
    output logic [SLOTS-1:0][NODE_W-1:0]   rd_ptrs,
    input  logic                           we,
    input  logic [BLK_W-1:0]               wr_blk,
    input  blk_state_e                     wr_state,
    input  logic [SLOTS-1:0]               wr_valid,
    input  logic [SLOTS-1:0][NODE_W-1:0]   wr_ptrs
);
    localparam int BLOCKS = 1 << BLK_W;

    blk_state_e                   st_q  [BLOCKS];
    logic [SLOTS-1:0]             vld_q [BLOCKS];
    logic [SLOTS-1:0][NODE_W-1:0] ptr_q [BLOCKS];

    // Read port: expose the addressed entry.
    assign rd_state = st_q[rd_blk];
    assign rd_valid = vld_q[rd_blk];
    assign rd_ptrs  = ptr_q[rd_blk];

    // State and valid bits: cleared at reset, written on we.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BLOCKS; b++) begin
                st_q[b]  <= BLK_UNCACHED;
                vld_q[b] <= '0;
            end
        end else if (we) begin
            st_q[wr_blk]  <= wr_state;
            vld_q[wr_blk] <= wr_valid;
        end
    end

    // Pointer contents: meaningful only under their valid bits, so no reset.
    always_ff @(posedge clk) begin
        if (we) begin
            ptr_q[wr_blk] <= wr_ptrs;
        end
    end

    // R2
    // shared_nonempty_chk
    shared_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_state == BLK_SHARED) |-> (wr_valid != '0));

endmodule

// File: rtl/lpd_ptr_match.sv
// Compares a node against an entry's pointers and finds the lowest free one.
// Assumes: a correct entry holds no node twice.
module lpd_ptr_match #(
    parameter int NODE_W = 6,
    parameter int SLOTS  = 4,
    parameter int IDX_W  = 2
) (
    input  logic [SLOTS-1:0]             valid,
    input  logic [SLOTS-1:0][NODE_W-1:0] ptrs,
    input  logic [NODE_W-1:0]            node,
    output logic                         hit,
    output logic [SLOTS-1:0]             hit_mask,
    output logic                         free_avail,
    output logic [IDX_W-1:0]             free_idx
);
    // One comparator per pointer.
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit_mask[g] = valid[g] && (ptrs[g] == node);
    end

    assign hit        = |hit_mask;
    assign free_avail = ~&valid;

    // Lowest free pointer wins.
    always_comb begin
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/lpd_inval_seq.sv
// Issues one invalidation per cycle for a pointer mask, lowest first, and
// counts acknowledgements; done rises once every one sent has been acked.
// Assumes: start only when idle, with a non-empty mask; acks follow invalidations.
module lpd_inval_seq #(
    parameter int NODE_W = 6,
    parameter int SLOTS  = 4,
    parameter int IDX_W  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [SLOTS-1:0]             start_mask,
    input  logic [SLOTS-1:0][NODE_W-1:0] start_ptrs,
    input  logic                         ack,
    output logic                         inv_valid,
    output logic [NODE_W-1:0]            inv_node,
    output logic                         done
);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic                         run_q;
    logic [SLOTS-1:0]             pend_q;
    logic [SLOTS-1:0][NODE_W-1:0] ptrs_q;
    logic [CNT_W-1:0]             sent_q;
    logic [CNT_W-1:0]             acks_q;
    logic [IDX_W-1:0]             low_idx;

    // Select the lowest pending pointer.
    always_comb begin
        low_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (pend_q[i]) low_idx = IDX_W'(i);
        end
    end

    assign inv_valid = run_q && (pend_q != '0);
    assign inv_node  = ptrs_q[low_idx];
    assign done      = run_q && (pend_q == '0) && (acks_q == sent_q);

    // Run control, pending mask and the two counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            pend_q <= '0;
            sent_q <= '0;
            acks_q <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            pend_q <= start_mask;
            sent_q <= '0;
            acks_q <= '0;
        end else if (run_q) begin
            if (inv_valid) begin
                pend_q <= pend_q & ~(SLOTS'(1) << low_idx);
                sent_q <= sent_q + CNT_W'(1);
            end
            if (ack && !done) acks_q <= acks_q + CNT_W'(1);
            if (done) run_q <= 1'b0;
        end
    end

    // Latch the pointer list at start.
    always_ff @(posedge clk) begin
        if (start) ptrs_q <= start_ptrs;
    end

    // R7
    // ack_bound_chk
    ack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (acks_q <= sent_q));

    // R7
    // start_idle_chk
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!run_q && start_mask != '0));

endmodule

// File: rtl/limptr_dir.sv
// Limited-pointer directory controller for one memory module. Reads record
// sharers; writes invalidate other sharers and wait for acks; a pointer
// overflow (or any request with zero pointers) traps to the local processor
// and the block stays software-managed from then on.
// Assumes: single-cycle request pulses; trap_done pulses only after trap_valid.
module limptr_dir
    import limptr_pkg::*;
#(
    parameter int NODE_W   = 6,
    parameter int NUM_PTRS = 4,
    parameter int BLK_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [NODE_W-1:0] req_node,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic              ack_valid,
    input  logic              trap_done,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [NODE_W-1:0] rsp_node,
    output logic              nak_valid,
    output logic [NODE_W-1:0] nak_node,
    output logic              inv_valid,
    output logic [NODE_W-1:0] inv_node,
    output logic              trap_valid,
    output logic [BLK_W-1:0]  trap_blk,
    output logic [NODE_W-1:0] trap_node,
    output logic              trap_write
);
    localparam bit ZERO_PTR = (NUM_PTRS == 0);
    localparam int SLOTS    = ZERO_PTR ? 1 : NUM_PTRS;
    localparam int IDX_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    ctl_state_e                   ctl_q, ctl_n;
    logic [NODE_W-1:0]            cur_node_q;
    logic [BLK_W-1:0]             cur_blk_q;
    logic                         cur_write_q;

    blk_state_e                   rd_state;
    logic [SLOTS-1:0]             rd_valid;
    logic [SLOTS-1:0][NODE_W-1:0] rd_ptrs;
    logic                         we;
    logic [BLK_W-1:0]             wr_blk;
    blk_state_e                   wr_state;
    logic [SLOTS-1:0]             wr_valid;
    logic [SLOTS-1:0][NODE_W-1:0] wr_ptrs;

    logic                         hit, free_avail;
    logic [SLOTS-1:0]             hit_mask;
    logic [IDX_W-1:0]             free_idx;

    logic                         seq_start, seq_done;
    logic [SLOTS-1:0]             seq_mask;

    logic                         rsp_v_n, nak_v_n, trap_set;
    logic [1:0]                   rsp_k_n;
    logic [NODE_W-1:0]            rsp_node_n;
    logic                         needs_trap;
    logic [SLOTS-1:0]             other_mask;

    lpd_entry_store #(.NODE_W(NODE_W), .SLOTS(SLOTS), .BLK_W(BLK_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_blk(req_blk), .rd_state(rd_state), .rd_valid(rd_valid), .rd_ptrs(rd_ptrs),
        .we(we), .wr_blk(wr_blk), .wr_state(wr_state), .wr_valid(wr_valid), .wr_ptrs(wr_ptrs)
    );

    lpd_ptr_match #(.NODE_W(NODE_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_match (
        .valid(rd_valid), .ptrs(rd_ptrs), .node(req_node),
        .hit(hit), .hit_mask(hit_mask), .free_avail(free_avail), .free_idx(free_idx)
    );

    lpd_inval_seq #(.NODE_W(NODE_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(seq_start), .start_mask(seq_mask), .start_ptrs(rd_ptrs),
        .ack(ack_valid), .inv_valid(inv_valid), .inv_node(inv_node), .done(seq_done)
    );

    assign other_mask = rd_valid & ~hit_mask;
    assign needs_trap = ZERO_PTR || (rd_state == BLK_OVERFLOW) ||
                        (!req_write && rd_state != BLK_EXCL && !hit && !free_avail);

    // Request decode and completion: picks the response, entry update and next state.
    always_comb begin
        ctl_n      = ctl_q;
        rsp_v_n    = 1'b0;
        rsp_k_n    = RSP_SHARED;
        rsp_node_n = req_node;
        nak_v_n    = 1'b0;
        trap_set   = 1'b0;
        seq_start  = 1'b0;
        seq_mask   = other_mask;
        we         = 1'b0;
        wr_blk     = req_blk;
        wr_state   = rd_state;
        wr_valid   = rd_valid;
        wr_ptrs    = rd_ptrs;
        if (ctl_q == CTL_BUSY) begin
            nak_v_n = req_valid;
            if (seq_done) begin
                ctl_n       = CTL_IDLE;
                we          = 1'b1;
                wr_blk      = cur_blk_q;
                wr_state    = cur_write_q ? BLK_EXCL : BLK_SHARED;
                wr_valid    = '0;
                wr_valid[0] = 1'b1;
                wr_ptrs[0]  = cur_node_q;
                rsp_v_n     = 1'b1;
                rsp_k_n     = cur_write_q ? RSP_EXCL : RSP_SHARED;
                rsp_node_n  = cur_node_q;
            end
        end else if (req_valid) begin
            if (trap_valid && req_blk == trap_blk) begin
                nak_v_n = 1'b1;
            end else if (needs_trap) begin
                if (trap_valid) begin
                    nak_v_n = 1'b1;
                end else begin
                    trap_set = 1'b1;
                    we       = 1'b1;
                    wr_state = BLK_OVERFLOW;
                    rsp_v_n  = 1'b1;
                    rsp_k_n  = RSP_TRAPPED;
                end
            end else if (req_write) begin
                if (other_mask == '0) begin
                    we          = 1'b1;
                    wr_state    = BLK_EXCL;
                    wr_valid    = '0;
                    wr_valid[0] = 1'b1;
                    wr_ptrs[0]  = req_node;
                    rsp_v_n     = 1'b1;
                    rsp_k_n     = RSP_EXCL;
                end else begin
                    seq_start = 1'b1;
                    ctl_n     = CTL_BUSY;
                end
            end else if (hit) begin
                rsp_v_n = 1'b1;
            end else if (rd_state == BLK_EXCL) begin
                seq_start = 1'b1;
                ctl_n     = CTL_BUSY;
            end else begin
                we                = 1'b1;
                wr_state          = BLK_SHARED;
                wr_valid[free_idx] = 1'b1;
                wr_ptrs[free_idx]  = req_node;
                rsp_v_n           = 1'b1;
            end
        end
    end

    // Control state and the request held during an invalidation run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= CTL_IDLE;
            cur_node_q  <= '0;
            cur_blk_q   <= '0;
            cur_write_q <= 1'b0;
        end else begin
            ctl_q <= ctl_n;
            if (seq_start) begin
                cur_node_q  <= req_node;
                cur_blk_q   <= req_blk;
                cur_write_q <= req_write;
            end
        end
    end

    // Registered response and NACK outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= RSP_SHARED;
            rsp_node  <= '0;
            nak_valid <= 1'b0;
            nak_node  <= '0;
        end else begin
            rsp_valid <= rsp_v_n;
            rsp_kind  <= rsp_k_n;
            rsp_node  <= rsp_node_n;
            nak_valid <= nak_v_n;
            nak_node  <= req_node;
        end
    end

    // Trap register: set by an overflowing request, cleared by trap_done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_valid <= 1'b0;
            trap_blk   <= '0;
            trap_node  <= '0;
            trap_write <= 1'b0;
        end else if (trap_set) begin
            trap_valid <= 1'b1;
            trap_blk   <= req_blk;
            trap_node  <= req_node;
            trap_write <= req_write;
        end else if (trap_done) begin
            trap_valid <= 1'b0;
        end
    end

    // R10
    // busy_nak_chk
    busy_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctl_q == CTL_BUSY) |=> nak_valid);

    // R5
    // trap_hold_chk
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_done) |=> (trap_valid && $stable(trap_blk) && $stable(trap_node)));

    // R11
    // zero_trap_chk
    zero_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ZERO_PTR && rsp_valid) |-> (rsp_kind == RSP_TRAPPED));

    // R7
    // inv_busy_chk
    inv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (ctl_q == CTL_BUSY));

    // R3
    // hit_unique_chk
    hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctl_q == CTL_IDLE) |-> $onehot0(hit_mask));

endmodule

// File: tb/test_limptr_dir.sv
module test_limptr_dir;
    localparam int NODE_W = 6;
    localparam int BLK_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, ack_valid = 1'b0, trap_done = 1'b0;
    logic [NODE_W-1:0] req_node = '0;
    logic [BLK_W-1:0]  req_blk = '0;
    logic rsp_valid, nak_valid, inv_valid, trap_valid, trap_write;
    logic [1:0] rsp_kind;
    logic [NODE_W-1:0] rsp_node, nak_node, inv_node, trap_node;
    logic [BLK_W-1:0] trap_blk;

    logic z_req_valid = 1'b0, z_req_write = 1'b0, z_trap_done = 1'b0;
    logic [NODE_W-1:0] z_req_node = '0;
    logic [BLK_W-1:0]  z_req_blk = '0;
    logic z_rsp_valid, z_nak_valid, z_inv_valid, z_trap_valid, z_trap_write;
    logic [1:0] z_rsp_kind;
    logic [NODE_W-1:0] z_rsp_node, z_nak_node, z_inv_node, z_trap_node;
    logic [BLK_W-1:0] z_trap_blk;

    limptr_dir #(.NODE_W(NODE_W), .NUM_PTRS(4), .BLK_W(BLK_W)) i_limptr_dir (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_node(req_node), .req_blk(req_blk), .ack_valid(ack_valid), .trap_done(trap_done),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_node(rsp_node),
        .nak_valid(nak_valid), .nak_node(nak_node), .inv_valid(inv_valid), .inv_node(inv_node),
        .trap_valid(trap_valid), .trap_blk(trap_blk), .trap_node(trap_node), .trap_write(trap_write));

    limptr_dir #(.NODE_W(NODE_W), .NUM_PTRS(0), .BLK_W(BLK_W)) i_limptr_dir_zero (
        .clk(clk), .rst_n(rst_n), .req_valid(z_req_valid), .req_write(z_req_write),
        .req_node(z_req_node), .req_blk(z_req_blk), .ack_valid(1'b0), .trap_done(z_trap_done),
        .rsp_valid(z_rsp_valid), .rsp_kind(z_rsp_kind), .rsp_node(z_rsp_node),
        .nak_valid(z_nak_valid), .nak_node(z_nak_node), .inv_valid(z_inv_valid), .inv_node(z_inv_node),
        .trap_valid(z_trap_valid), .trap_blk(z_trap_blk), .trap_node(z_trap_node), .trap_write(z_trap_write));

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Scoreboard item: chan 0 = invalidation, 1 = response, 2 = NACK.
    typedef struct {
        int    due;
        int    chan;
        int    node;
        int    kind;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic push(input int due, input int chan, input int node, input int kind, input string tag);
        exp_t it;
        int pos;
        it.due = due; it.chan = chan; it.node = node; it.kind = kind; it.tag = tag;
        pos = exp_q.size();
        for (int i = 0; i < exp_q.size(); i++) begin
            if (exp_q[i].due > due || (exp_q[i].due == due && exp_q[i].chan > chan)) begin
                pos = i;
                break;
            end
        end
        exp_q.insert(pos, it);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic observe(input int chan, input int node, input int kind);
        exp_t it;
        if (exp_q.size() == 0) begin
            chk(1'b0, "unexpected output", chan, -1);
            return;
        end
        it = exp_q.pop_front();
        chk(it.due == cyc && it.chan == chan, {it.tag, " timing/channel"}, cyc * 4 + chan, it.due * 4 + it.chan);
        chk(it.node == node, {it.tag, " node"}, node, it.node);
        chk(it.kind == kind, {it.tag, " kind"}, kind, it.kind);
    endtask

    // Monitor: pops and compares at each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            while (exp_q.size() > 0 && exp_q[0].due < cyc) begin
                exp_t it;
                it = exp_q.pop_front();
                chk(1'b0, {it.tag, " missing output"}, cyc, it.due);
            end
            if (inv_valid) observe(0, int'(inv_node), 0);
            if (rsp_valid) observe(1, int'(rsp_node), int'(rsp_kind));
            if (nak_valid) observe(2, int'(nak_node), 0);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle request with its expected immediate response.
    task automatic req(input bit w, input int node, input int blk, input int chan, input int kind, input string tag);
        int c;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_node = NODE_W'(node); req_blk = BLK_W'(blk);
        c = cyc;
        push(c + 1, chan, node, kind, tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Request that starts an invalidation run of n targets, acked after the last one.
    task automatic inval_req(input bit w, input int node, input int blk, input int n,
                             input int t0, input int t1, input int t2, input bit with_nak, input string tag);
        int c;
        int tl[3];
        tl[0] = t0; tl[1] = t1; tl[2] = t2;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_node = NODE_W'(node); req_blk = BLK_W'(blk);
        c = cyc;
        for (int i = 0; i < n; i++) push(c + 1 + i, 0, tl[i], 0, tag);
        push(c + 2 * n + 2, 1, node, w ? 1 : 0, tag);
        @(negedge clk);
        if (with_nak) begin
            // R10: a request during the run is refused next cycle
            req_node = NODE_W'(20); req_blk = BLK_W'(7); req_write = 1'b0;
            push(c + 2, 2, 20, 0, "R10");
        end else begin
            req_valid = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        while (cyc < c + n + 1) @(negedge clk);
        ack_valid = 1'b1;
        repeat (n) @(negedge clk);
        ack_valid = 1'b0;
        idle(3);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        trap_done = 1'b1;
        @(negedge clk);
        trap_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during and after reset
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && !nak_valid && !inv_valid && !trap_valid, "R1 quiet after reset",
            int'({rsp_valid, nak_valid, inv_valid, trap_valid}), 0);

        // R2 / R3: sharers 10, 11, repeat 10, then 12, 13 all fit
        req(1'b0, 10, 3, 1, 0, "R2");
        req(1'b0, 11, 3, 1, 0, "R2");
        req(1'b0, 10, 3, 1, 0, "R3");
        req(1'b0, 12, 3, 1, 0, "R3");
        req(1'b0, 13, 3, 1, 0, "R3");
        idle(1);
        // R7: writer 11 invalidates 10, 12, 13 in slot order; R10 nak during run
        inval_req(1'b1, 11, 3, 3, 10, 12, 13, 1'b1, "R7");

        // R9: owner reread, then another reader recalls the owner
        req(1'b0, 11, 3, 1, 0, "R9");
        inval_req(1'b0, 30, 3, 1, 11, 0, 0, 1'b0, "R9");
        // R8: sole sharer writes, no invalidation; fresh block write too
        req(1'b1, 30, 3, 1, 1, "R8");
        req(1'b1, 40, 9, 1, 1, "R8");
        inval_req(1'b1, 50, 3, 1, 30, 0, 0, 1'b0, "R7");

        // R4: fifth distinct reader traps
        req(1'b0, 1, 5, 1, 0, "R2");
        req(1'b0, 2, 5, 1, 0, "R2");
        req(1'b0, 3, 5, 1, 0, "R2");
        req(1'b0, 4, 5, 1, 0, "R2");
        req(1'b0, 6, 5, 1, 2, "R4");
        chk(trap_valid && trap_blk == 4'd5 && trap_node == 6'd6 && !trap_write, "R4 trap fields",
            int'({trap_valid, trap_blk, trap_node, trap_write}), int'({1'b1, 4'd5, 6'd6, 1'b0}));
        // R5: same block refused, other block served, trap held
        req(1'b0, 1, 5, 2, 0, "R5");
        req(1'b0, 7, 8, 1, 0, "R5");
        idle(2);
        chk(trap_valid && trap_blk == 4'd5 && trap_node == 6'd6, "R5 trap held",
            int'({trap_valid, trap_blk}), int'({1'b1, 4'd5}));
        pulse_done();
        chk(!trap_valid, "R5 trap cleared", int'(trap_valid), 0);

        // R6: overflow block keeps trapping, reads and writes
        req(1'b0, 1, 5, 1, 2, "R6");
        chk(trap_valid && trap_node == 6'd1 && !trap_write, "R6 read trap",
            int'({trap_valid, trap_node}), int'({1'b1, 6'd1}));
        pulse_done();
        req(1'b1, 2, 5, 1, 2, "R6");
        chk(trap_valid && trap_node == 6'd2 && trap_write, "R6 write trap",
            int'({trap_valid, trap_node, trap_write}), int'({1'b1, 6'd2, 1'b1}));
        pulse_done();
        idle(2);

        // R11: zero-pointer instance traps every request
        @(negedge clk);
        z_req_valid = 1'b1; z_req_write = 1'b0; z_req_node = 6'd9; z_req_blk = 4'd0;
        @(negedge clk);
        z_req_valid = 1'b0;
        chk(z_rsp_valid && z_rsp_kind == 2'd2 && z_trap_valid, "R11 read trap",
            int'({z_rsp_valid, z_rsp_kind, z_trap_valid}), int'({1'b1, 2'd2, 1'b1}));
        z_trap_done = 1'b1;
        @(negedge clk);
        z_trap_done = 1'b0;
        z_req_valid = 1'b1; z_req_write = 1'b1; z_req_node = 6'd4; z_req_blk = 4'd2;
        @(negedge clk);
        z_req_valid = 1'b0;
        chk(z_rsp_valid && z_rsp_kind == 2'd2 && z_trap_write && z_rsp_node == 6'd4, "R11 write trap",
            int'({z_rsp_valid, z_rsp_kind, z_trap_write}), int'({1'b1, 2'd2, 1'b1}));
        idle(3);

        while (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            chk(1'b0, {it.tag, " never produced"}, cyc, it.due);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected 0 (run did not finish)", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule